// File: doc/BRIEF.md
# Transmit FIFO Refill Controller

This block manages the transmit-side FIFOs of a multi-channel serial framer. Each channel owns a FIFO whose occupancy the controller tracks. The framing engines ask for words, and the controller grants them one port per cycle. Host data reaches the FIFOs through a DMA engine. The controller chooses which channel the DMA refills next, holds that choice while the burst runs, and ends the burst when the FIFO is full or when the DMA signals that it has nothing more for the channel.

A channel becomes a refill candidate only under three conditions: it is enabled, its occupancy is under the low watermark, and the DMA has flagged host data for it. Refill candidates are picked either in fixed order, with the lowest index first, or in rotating order. The `rr_mode` input selects between the two.

Engine delivery is held back until a channel is primed. A channel becomes primed when its occupancy rises above the low watermark, or when an end-of-frame word is written into it. It then stays primed until it has drained to empty. This way, short frames are not held waiting for a watermark they will never reach.

Top module: `tx_refill_ctrl`

## Requirements
- R1: After reset, every FIFO level is 0, no engine grant is asserted and `refill_busy` is low.
- R2: In any cycle, at most one `eng_gnt` bit is set. It goes to the lowest-indexed eligible port. Each grant removes one word from that port's level at the next edge.
- R3: A port is eligible when it is enabled, requesting, primed and non-empty. It becomes primed when a write takes its level above `LOW_WM`, or when a write carries `dma_eof`. It stops being primed when a read leaves it empty.
- R4: A channel is a refill candidate only when it is enabled, its data-available flag is set and its level is below `LOW_WM`.
- R5: With `rr_mode` low, the lowest-indexed candidate receives the refill grant. Index 0 is the highest priority.
- R6: With `rr_mode` high, the search for the next refill grant starts at the index after the last channel granted, wrapping to 0. After reset, the search starts at 0.
- R7: At most one refill grant is outstanding. `refill_ch` holds steady while `refill_busy` is high. A new grant can be issued only in a cycle that starts with `refill_busy` low.
- R8: While busy, each `dma_wr` adds one word to the granted channel. The grant ends at the edge where a write brings the level to `DEPTH`, or where `dma_last` is high. At that point the channel's data-available flag clears, unless `dma_avail_set` sets it again in the same cycle. A level never exceeds `DEPTH`.
- R9: Disabled channels receive neither engine grants nor refill grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Per-channel enable |
| rr_mode | input | 1 | 1 selects rotating refill order, 0 selects fixed order |
| dma_avail_set | input | NCH | Pulse that sets a channel's data-available flag |
| eng_req | input | NCH | Engine word requests |
| eng_gnt | output | NCH | One-hot word grant to an engine |
| dma_wr | input | 1 | A DMA word is written into the granted channel |
| dma_eof | input | 1 | The written word ends a frame |
| dma_last | input | 1 | The DMA has no more data for the granted channel |
| refill_busy | output | 1 | A refill grant is outstanding |
| refill_ch | output | CW | Channel of the outstanding refill grant |
| fifo_level | output | NCH*LW | Per-channel occupancy, channel 0 in the low bits |

## Verification
A single FIFO can be written by the DMA and read by its engine in the same cycle. A grant can also end in the same cycle that the host sets the same channel's data-available flag again. The bench provokes the first case by requesting the granted channel during a burst. It provokes the second by pulsing `dma_avail_set` together with `dma_last`. A cycle-level reference model then judges the resulting level and whether the channel is granted again. A randomized phase makes both collisions happen many more times.

// File: rtl/tx_refill_pkg.sv
package tx_refill_pkg;
  // Next occupancy for one write/read pair.
  function automatic int unsigned fill_step(int unsigned f, logic wr, logic rd);
    return f + (wr ? 1 : 0) - (rd ? 1 : 0);
  endfunction

  // Rotating start index: one past the last grant, wrapping at n.
  function automatic int unsigned rr_start(int unsigned last, int unsigned n);
    return (last + 1 >= n) ? 0 : last + 1;
  endfunction
endpackage

// File: rtl/trc_pick.sv
module trc_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic [N-1:0] gnt,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    int j;
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any    = 1'b1;
        gnt[j] = 1'b1;
        idx    = W'(j);
      end
    end
  end
endmodule

// File: rtl/trc_chan.sv
module trc_chan
  import tx_refill_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LOW_WM = 3,
  parameter int LW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          eof,
  input  logic          rd,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt,
  output logic          primed,
  output logic          below_lw
);
  logic prime_set, prime_clr;

  assign level_nxt = LW'(fill_step(int'(level), wr, rd));
  assign below_lw  = int'(level) < LOW_WM;
  assign prime_set = (int'(level_nxt) > LOW_WM) || (wr && eof);
  assign prime_clr = rd && (level_nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level  <= '0;
      primed <= 1'b0;
    end else begin
      level <= level_nxt;
      if (prime_set)      primed <= 1'b1;
      else if (prime_clr) primed <= 1'b0;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
  p_read_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (primed && level != '0));
  p_prime_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(primed) |-> level == '0);
endmodule

// File: rtl/tx_refill_ctrl.sv
module tx_refill_ctrl
  import tx_refill_pkg::*;
#(
  parameter int NCH    = 40,
  parameter int DEPTH  = 64,
  parameter int LOW_WM = 16,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic              rr_mode,
  input  logic [NCH-1:0]    dma_avail_set,
  input  logic [NCH-1:0]    eng_req,
  output logic [NCH-1:0]    eng_gnt,
  input  logic              dma_wr,
  input  logic              dma_eof,
  input  logic              dma_last,
  output logic              refill_busy,
  output logic [CW-1:0]     refill_ch,
  output logic [NCH*LW-1:0] fifo_level
);
  logic [NCH-1:0] avail, primed, below, eng_elig, refill_req, wr_vec, clr_vec;
  logic [LW-1:0]  lvl [NCH];
  logic [LW-1:0]  lvl_nxt [NCH];
  logic [CW-1:0]  last_ch, rr_from, pick_ch, eng_idx;
  logic           pick_any, eng_any, burst_done, burst_full, issue;
  logic [NCH-1:0] pick_onehot;

  // Eligibility vectors brought out as named wires.
  assign eng_elig   = eng_req & chan_en & primed;
  assign refill_req = chan_en & avail & below;

  trc_pick #(.N(NCH), .W(CW)) u_eng_pick (
    .req(eng_elig), .start('0), .gnt(eng_gnt), .idx(eng_idx), .any(eng_any));

  assign rr_from = rr_mode ? CW'(rr_start(int'(last_ch), NCH)) : '0;

  trc_pick #(.N(NCH), .W(CW)) u_refill_pick (
    .req(refill_req), .start(rr_from), .gnt(pick_onehot), .idx(pick_ch), .any(pick_any));

  always_comb begin
    wr_vec  = '0;
    clr_vec = '0;
    if (refill_busy && dma_wr) wr_vec[refill_ch] = 1'b1;
    if (burst_done)            clr_vec[refill_ch] = 1'b1;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      trc_chan #(.DEPTH(DEPTH), .LOW_WM(LOW_WM), .LW(LW)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_vec[c]), .eof(dma_eof), .rd(eng_gnt[c]),
        .level(lvl[c]), .level_nxt(lvl_nxt[c]),
        .primed(primed[c]), .below_lw(below[c]));
      assign fifo_level[c*LW +: LW] = lvl[c];
    end
  endgenerate

  assign burst_full = dma_wr && (int'(lvl_nxt[refill_ch]) == DEPTH);
  assign burst_done = refill_busy && (burst_full || dma_last);
  assign issue      = !refill_busy && pick_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refill_busy <= 1'b0;
      refill_ch   <= '0;
      last_ch     <= CW'(NCH - 1);
      avail       <= '0;
    end else begin
      avail <= (avail & ~clr_vec) | dma_avail_set;
      if (burst_done) begin
        refill_busy <= 1'b0;
      end else if (issue) begin
        refill_busy <= 1'b1;
        refill_ch   <= pick_ch;
        last_ch     <= pick_ch;
      end
    end
  end

  p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_gnt));
  p_gnt_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_gnt & ~chan_en) == '0);
  p_grant_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_busy && $past(refill_busy)) |-> $stable(refill_ch));
  p_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refill_busy) |-> ((($past(refill_req) >> refill_ch) & 1) != 0));
  p_avail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && dma_avail_set == '0) |=> ((avail >> $past(refill_ch)) & 1) == 0);
endmodule

// File: tb/tx_refill_ctrl_tb_top.sv
module tx_refill_ctrl_tb_top;
  localparam int NCH = 4, DEPTH = 8, LOW_WM = 3, CW = 2, LW = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] chan_en = '0, dma_avail_set = '0, eng_req = '0, eng_gnt;
  logic rr_mode = 0, dma_wr = 0, dma_eof = 0, dma_last = 0, refill_busy;
  logic [CW-1:0] refill_ch;
  logic [NCH*LW-1:0] fifo_level;

  always #2.5 clk = ~clk;  // 200 MHz

  tx_refill_ctrl #(.NCH(NCH), .DEPTH(DEPTH), .LOW_WM(LOW_WM)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rr_mode(rr_mode),
    .dma_avail_set(dma_avail_set), .eng_req(eng_req), .eng_gnt(eng_gnt),
    .dma_wr(dma_wr), .dma_eof(dma_eof), .dma_last(dma_last),
    .refill_busy(refill_busy), .refill_ch(refill_ch), .fifo_level(fifo_level));

  typedef struct {
    logic [NCH-1:0]    gnt;
    logic              busy;
    logic [CW-1:0]     ch;
    logic [NCH*LW-1:0] lvl;
    string             tag;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  // Reference model state.
  int m_fill [NCH];
  bit m_primed [NCH];
  bit [NCH-1:0] m_avail;
  bit m_busy;
  int m_ch, m_last;

  function automatic logic [NCH-1:0] m_gnt();
    for (int i = 0; i < NCH; i++)
      if (eng_req[i] && chan_en[i] && m_primed[i] && m_fill[i] > 0)
        return NCH'(1) << i;
    return '0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_fill[i] = 0; m_primed[i] = 0; end
    m_avail = '0; m_busy = 0; m_ch = 0; m_last = NCH - 1;
  endtask

  task automatic model_advance();
    logic [NCH-1:0] g;
    bit done;
    int nf, st, win;
    g = m_gnt();
    done = 0;
    for (int i = 0; i < NCH; i++) begin
      bit w;
      w = m_busy && dma_wr && (m_ch == i);
      nf = m_fill[i] + (w ? 1 : 0) - (g[i] ? 1 : 0);
      if (w && nf == DEPTH) done = 1;
      if (nf > LOW_WM || (w && dma_eof)) m_primed[i] = 1;
      else if (g[i] && nf == 0) m_primed[i] = 0;
      m_fill[i] = nf;
    end
    if (m_busy && dma_last) done = 1;
    win = -1;
    if (!m_busy) begin
      st = rr_mode ? ((m_last + 1) % NCH) : 0;
      for (int k = 0; k < NCH; k++) begin
        int j;
        j = (st + k) % NCH;
        if (win < 0 && chan_en[j] && m_avail[j] && m_fill[j] - (g[j] ? 0 : 0) < LOW_WM + 0
            && (m_fill[j] + (g[j] ? 1 : 0)) < LOW_WM) win = j;
      end
    end
    if (m_busy && done) begin
      m_avail[m_ch] = 0;
      m_busy = 0;
    end else if (win >= 0) begin
      m_busy = 1; m_ch = win; m_last = win;
    end
    m_avail = m_avail | dma_avail_set;
  endtask

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      exp_t e;
      wait (sbq.size() > 0);
      e = sbq.pop_front();
      checks++;
      if (eng_gnt !== e.gnt) begin
        errors++;
        $display("FAIL %s eng_gnt actual %b expected %b", e.tag, eng_gnt, e.gnt);
      end
      checks++;
      if (refill_busy !== e.busy) begin
        errors++;
        $display("FAIL %s refill_busy actual %b expected %b", e.tag, refill_busy, e.busy);
      end
      if (e.busy) begin
        checks++;
        if (refill_ch !== e.ch) begin
          errors++;
          $display("FAIL %s refill_ch actual %0d expected %0d", e.tag, refill_ch, e.ch);
        end
      end
      checks++;
      if (fifo_level !== e.lvl) begin
        errors++;
        $display("FAIL %s fifo_level actual %h expected %h", e.tag, fifo_level, e.lvl);
      end
    end
  end

  // Driver: applies one cycle of stimulus, pushes the expectation, advances the model.
  task automatic step(input logic [NCH-1:0] en, input logic rr, input logic [NCH-1:0] set,
                      input logic [NCH-1:0] req, input logic wr, input logic eof,
                      input logic last);
    exp_t e;
    @(negedge clk);
    chan_en = en; rr_mode = rr; dma_avail_set = set; eng_req = req;
    dma_wr = wr; dma_eof = eof; dma_last = last;
    #1;
    e.gnt = m_gnt(); e.busy = m_busy; e.ch = CW'(m_ch); e.tag = tag;
    for (int i = 0; i < NCH; i++) e.lvl[i*LW +: LW] = LW'(m_fill[i]);
    sbq.push_back(e);
    wait (sbq.size() == 0);
    model_advance();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    tag = "R1";
    step('0, 0, '0, '0, 0, 0, 0);
    // R4: no data-available flag means no refill
    tag = "R4";
    repeat (2) step('1, 0, '0, '0, 0, 0, 0);
    // R9: disabled channel 2 with data available is never granted
    tag = "R9";
    step(4'b1011, 0, 4'b0100, '0, 0, 0, 0);
    repeat (3) step(4'b1011, 0, '0, '0, 0, 0, 0);
    // R5: fixed order, channels 0 and 2 pending, 0 wins
    tag = "R5";
    step('1, 0, 4'b0001, '0, 0, 0, 0);
    step('1, 0, '0, '0, 0, 0, 0);
    // R8: burst fills channel 0 to DEPTH, then ends
    tag = "R8";
    repeat (DEPTH) step('1, 0, '0, '0, 1, 0, 0);
    step('1, 0, '0, '0, 0, 0, 0);
    // R3: short frame into channel 2 with end-of-frame, primed below watermark
    tag = "R3";
    step('1, 0, '0, '0, 1, 0, 0);
    step('1, 0, '0, '0, 1, 1, 1);
    // R2: both ports request, port 0 drains first
    tag = "R2";
    repeat (12) step('1, 0, '0, 4'b0101, 0, 0, 0);
    // R8: avail re-set in the cycle the grant ends keeps the channel pending
    tag = "R8";
    step('1, 0, 4'b0010, '0, 0, 0, 0);
    step('1, 0, '0, '0, 0, 0, 0);
    step('1, 0, 4'b0010, 4'b0010, 1, 0, 1);
    repeat (4) step('1, 0, '0, '0, 0, 0, 0);
    step('1, 0, '0, '0, 0, 0, 1);
    // R6: rotating order across all channels
    tag = "R6";
    step('1, 1, 4'b1111, '0, 0, 0, 0);
    repeat (10) step('1, 1, '0, '1, 1, 0, 1);
    step('1, 1, 4'b1111, '0, 0, 0, 0);
    repeat (10) step('1, 1, '0, '1, 0, 0, 1);
    // R7: randomized traffic, collisions of writes, reads and flag sets
    tag = "R7";
    for (int n = 0; n < 3000; n++) begin
      logic [NCH-1:0] en;
      en = ($urandom_range(0, 7) == 0) ? NCH'($urandom) : '1;
      step(en, n[9], NCH'($urandom) & NCH'($urandom), NCH'($urandom),
           $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 9) == 0);
    end
    finish_run();
  end
endmodule